// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write an external asynchronous static RAM of 128K bytes. The host issues one access at a time through a request/ready handshake: with `ready` high, a cycle with `req` high is accepted and the address, write data and direction flag are captured. The controller then runs a fixed sequence of memory-pin states whose lengths are cycle counts derived, rounded up, from picosecond timing parameters and the clock period parameter.

On the memory side it drives an active-low and an active-high chip select as a pair, a write strobe, an output enable, the address bus and a split tri-state data bus (output value, output enable, input value). Writes place the address with both selects active and the write strobe high first, then open the write window with the data drivers on, and close the window, the selects and the drivers on one edge. Reads select the part with output enable low, sample the data bus once the access time has elapsed, return the byte with a single-cycle strobe, and wait out the bus release time before the next access may begin.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and after a reset that cuts an access short, ready is 1, rvalid is 0, the active-low select, write strobe and output enable are 1, the active-high select is 0 and the data drivers are off.
- R2: The two chip selects always show the same state (active-low select low exactly when active-high select high); they are active only during an accepted access and inactive whenever ready is 1.
- R3: The write strobe is low only while both selects are active and output enable is high; the data drivers are on exactly while the write strobe is low; the selects are active for SETUP cycles (5 with defaults) before the write strobe falls.
- R4: The address bus carries the address captured at acceptance and holds it while the part is selected; host inputs changing after acceptance have no effect.
- R5: The write strobe stays low for PULSE cycles (10 with defaults) with the write data constant, and the byte written is the one captured at acceptance.
- R6: A read drives output enable low together with the selects from the cycle after acceptance, samples the data bus ACC cycles (14 with defaults) after acceptance, and shows that byte on rdata with rvalid high in the following cycle.
- R7: rvalid is high for exactly one cycle per read and never for a write.
- R8: ready falls in the cycle after acceptance and returns 16 cycles after acceptance for a write and 19 for a read (defaults); a request made while ready is low is ignored.
- R9: The data drivers are never on while output enable is low or while the memory is in read mode, and switch on no earlier than HZ cycles (5 with defaults) after the memory last saw a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Host access request |
| ready | output | 1 | Controller can accept a request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Host byte address |
| wdata | input | DATA_W | Host write byte |
| rdata | output | DATA_W | Read byte, valid with rvalid |
| rvalid | output | 1 | One-cycle read-data strobe |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_cs | output | 1 | Memory chip select, active high |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Data value to drive onto the bus |
| mem_dq_oe | output | 1 | Enable for the bus drivers |
| mem_dq_i | input | DATA_W | Value seen on the data bus |

## Verification
Every access is timed from the clock edge that accepts the request, and all ports are sampled at falling edges: the selects and address appear one edge later, the write strobe falls after 5 more edges and rises after a further 10, rvalid is seen at the 15th sample after acceptance and ready at the 17th (write) or 20th (read). The memory model in the bench returns inverted data until 14 selected read cycles have passed, so a sample taken even one cycle early shows up as wrong data, and it measures the write window length, the setup before it and the gap between the last read and the data drivers turning on. Reads compare against a shadow copy updated only by accepted writes, which also exposes a request slipped in while busy.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WREC   = 3'd3,
        ST_RACC   = 3'd4,
        ST_RTURN  = 3'd5
    } ctl_state_e;

    // Round a time in picoseconds up to whole clock cycles.
    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = capture;
        if (capture) cap_d.data = din;
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign rdata  = cap_q.data;
    assign rvalid = cap_q.vld;

    // R7
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = 4000,
    parameter int T_RC_PS   = 55000,
    parameter int T_AA_PS   = 55000,
    parameter int T_ACS_PS  = 55000,
    parameter int T_OE_PS   = 25000,
    parameter int T_WC_PS   = 55000,
    parameter int T_WP_PS   = 40000,
    parameter int T_AW_PS   = 45000,
    parameter int T_CW_PS   = 45000,
    parameter int T_DW_PS   = 25000,
    parameter int T_HZ_PS   = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    output logic              ready,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    // Phase lengths in cycles, each rounded up from the timing parameters.
    localparam int HZ_C    = ps_to_cyc(T_HZ_PS, CLK_PS);
    localparam int SETUP_C = imax(1, HZ_C);
    localparam int PULSE_C = imax(1, imax(imax(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_DW_PS, CLK_PS)),
                                          imax(ps_to_cyc(T_AW_PS, CLK_PS), ps_to_cyc(T_CW_PS, CLK_PS)) - SETUP_C));
    localparam int WREC_C  = imax(1, ps_to_cyc(T_WC_PS, CLK_PS) - SETUP_C - PULSE_C);
    localparam int ACC_C   = imax(1, imax(imax(ps_to_cyc(T_AA_PS, CLK_PS), ps_to_cyc(T_ACS_PS, CLK_PS)),
                                          ps_to_cyc(T_OE_PS, CLK_PS)));
    localparam int RTURN_C = imax(1, imax(HZ_C, ps_to_cyc(T_RC_PS, CLK_PS) - ACC_C));
    localparam int MAX_C   = imax(imax(SETUP_C, PULSE_C), imax(imax(WREC_C, ACC_C), RTURN_C));
    localparam int CNT_W   = $clog2(MAX_C + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] wdat;
        logic              cs_n;
        logic              cs;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_IDLE, adr: '0, wdat: '0,
        cs_n: 1'b1, cs: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0
    };

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             rd_capture;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_ctl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk     (clk),
        .rst     (rst),
        .capture (rd_capture),
        .din     (mem_dq_i),
        .rdata   (rdata),
        .rvalid  (rvalid)
    );

    always_comb begin
        ctl_d      = ctl_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        rd_capture = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req) begin
                    ctl_d.adr  = addr;
                    ctl_d.wdat = wdata;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.cs   = 1'b1;
                    tmr_load   = 1'b1;
                    if (wr) begin
                        ctl_d.st = ST_WSETUP;
                        tmr_val  = CNT_W'(SETUP_C - 1);
                    end else begin
                        ctl_d.st   = ST_RACC;
                        ctl_d.oe_n = 1'b0;
                        tmr_val    = CNT_W'(ACC_C - 1);
                    end
                end
            end
            ST_WSETUP: begin
                if (tmr_zero) begin
                    ctl_d.st    = ST_WPULSE;
                    ctl_d.we_n  = 1'b0;
                    ctl_d.dq_oe = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(PULSE_C - 1);
                end
            end
            ST_WPULSE: begin
                if (tmr_zero) begin
                    ctl_d.st    = ST_WREC;
                    ctl_d.we_n  = 1'b1;
                    ctl_d.dq_oe = 1'b0;
                    ctl_d.cs_n  = 1'b1;
                    ctl_d.cs    = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(WREC_C - 1);
                end
            end
            ST_RACC: begin
                if (tmr_zero) begin
                    rd_capture = 1'b1;
                    ctl_d.st   = ST_RTURN;
                    ctl_d.oe_n = 1'b1;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.cs   = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(RTURN_C - 1);
                end
            end
            ST_WREC, ST_RTURN: begin
                if (tmr_zero) ctl_d.st = ST_IDLE;
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RST;
        else     ctl_q <= ctl_d;
    end

    assign ready     = (ctl_q.st == ST_IDLE);
    assign mem_cs_n  = ctl_q.cs_n;
    assign mem_cs    = ctl_q.cs;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_addr  = ctl_q.adr;
    assign mem_dq_o  = ctl_q.wdat;
    assign mem_dq_oe = ctl_q.dq_oe;

    // R2
    sel_pair_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n == !mem_cs);

    // R2
    idle_desel_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R3
    we_window_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));

    // R3
    drv_follows_we_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe == !mem_we_n);

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R5
    wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

    // R6
    rd_oe_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n));

    // R7
    rvalid_desel_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (mem_cs_n && mem_oe_n && $past(!mem_oe_n)));

    // R9
    drv_turn_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (mem_oe_n && $past(mem_oe_n)));

endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;

    localparam int SETUP  = 5;
    localparam int PULSE  = 10;
    localparam int ACC    = 14;
    localparam int TURN   = 5;
    localparam int WR_RDY = 17;  // sample index of ready after a write
    localparam int RD_RV  = 15;  // sample index of rvalid after a read
    localparam int RD_RDY = 20;  // sample index of ready after a read

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready, rvalid;
    logic [7:0]  rdata;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_o, mem_dq_i;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sram_ctl dut (
        .clk(clk), .rst(rst), .req(req), .ready(ready), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [7:0] mem    [256];
    logic [7:0] shadow [256];
    logic       sel, rd_win, wr_win;
    int         acc_cnt = 0;
    int         sel_cnt = 0;
    int         since_rd = 100;
    int         wlen = 0;
    bit         pend = 0;
    logic [7:0] paddr, pdata;
    logic       oe_prev = 1'b0;

    assign sel    = !mem_cs_n && mem_cs;
    assign rd_win = sel && !mem_oe_n && mem_we_n;
    assign wr_win = sel && !mem_we_n;
    // The model returns inverted data until the access time has elapsed.
    assign mem_dq_i = rd_win ? ((acc_cnt >= ACC) ? mem[mem_addr[7:0]] : ~mem[mem_addr[7:0]])
                             : (mem_dq_oe ? mem_dq_o : 8'hzz);

    always @(negedge clk) begin
        if (rst) begin
            pend = 0; wlen = 0; sel_cnt = 0; acc_cnt = 0;
        end else begin
            if (rd_win && mem_dq_oe) check(0, "R9 contention", 1, 0);
            if (mem_dq_oe && !oe_prev) check(since_rd >= TURN, "R9 turnaround", since_rd, TURN);
            if (wr_win) begin
                if (!pend) begin
                    check(sel_cnt == SETUP, "R3 setup", sel_cnt, SETUP);
                    check(mem_dq_oe == 1'b1, "R3 drivers", mem_dq_oe, 1);
                    pend = 1; wlen = 1; paddr = mem_addr[7:0]; pdata = mem_dq_o;
                end else begin
                    wlen++;
                    check(mem_dq_o == pdata, "R5 data stable", mem_dq_o, pdata);
                end
            end else if (pend) begin
                check(wlen == PULSE, "R5 pulse", wlen, PULSE);
                mem[paddr] = pdata;
                pend = 0;
            end
            sel_cnt  = sel ? sel_cnt + 1 : 0;
            acc_cnt  = rd_win ? acc_cnt + 1 : 0;
            since_rd = rd_win ? 0 : ((since_rd < 100) ? since_rd + 1 : since_rd);
        end
        oe_prev = mem_dq_oe;
    end

    // ---------------- one host access ----------------
    task automatic do_op(input logic w, input logic [16:0] a, input logic [7:0] d, input bit poke);
        int n, n_rv, n_rdy, rv_cnt;
        logic [7:0] got;
        while (!ready) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        n = 1;
        req = 1'b0; wr = ~w; addr = ~a; wdata = ~d;
        check(!mem_cs_n && mem_cs, "R2 select", {mem_cs_n, mem_cs}, 2'b01);
        check(mem_addr == a, "R4 address", mem_addr, a);
        check(mem_we_n == 1'b1, "R3 strobe high first", mem_we_n, 1);
        check(mem_oe_n == w, "R6 output enable", mem_oe_n, w);
        check(!ready, "R8 busy", ready, 0);
        n_rv = 0; n_rdy = 0; rv_cnt = 0; got = '0;
        while (n < 40 && n_rdy == 0) begin
            if (rvalid) begin rv_cnt++; n_rv = n; got = rdata; end
            if (ready) n_rdy = n;
            if (poke && n == 3) begin req = 1'b1; wr = 1'b1; addr = a; wdata = ~d; end
            if (poke && n == 4) req = 1'b0;
            if (n_rdy == 0) begin @(negedge clk); n++; end
        end
        if (w) begin
            shadow[a[7:0]] = d;
            check(rv_cnt == 0, "R7 no strobe on write", rv_cnt, 0);
            check(n_rdy == WR_RDY, "R8 write ready", n_rdy, WR_RDY);
        end else begin
            check(rv_cnt == 1, "R7 single strobe", rv_cnt, 1);
            check(n_rv == RD_RV, "R6 strobe cycle", n_rv, RD_RV);
            check(got == shadow[a[7:0]], "R6 read data", got, shadow[a[7:0]]);
            check(n_rdy == RD_RDY, "R8 read ready", n_rdy, RD_RDY);
        end
        check(mem_cs_n && !mem_cs, "R2 deselected when ready", {mem_cs_n, mem_cs}, 2'b10);
    endtask

    // {wr, addr, data}
    localparam logic [25:0] VEC [11] = '{
        {1'b1, 17'h00000, 8'h3C},
        {1'b1, 17'h1FFFF, 8'hC3},
        {1'b1, 17'h0AB12, 8'h5A},
        {1'b0, 17'h00000, 8'h00},
        {1'b0, 17'h1FFFF, 8'h00},
        {1'b1, 17'h00000, 8'hFF},
        {1'b0, 17'h0AB12, 8'h00},
        {1'b0, 17'h00000, 8'h00},
        {1'b1, 17'h10080, 8'h00},
        {1'b0, 17'h10080, 8'h00},
        {1'b0, 17'h1FFFF, 8'h00}
    };

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(ready && !rvalid, "R1 handshake", {ready, rvalid}, 2'b10);
        check(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 pins",
              {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);

        for (int i = 0; i < 11; i++) begin
            logic w;
            w = VEC[i][25];
            do_op(w, VEC[i][24:8], VEC[i][7:0], 1'b0);
        end

        // R8: a request raised while busy must not start a second write
        do_op(1'b1, 17'h0A044, 8'h96, 1'b1);
        do_op(1'b0, 17'h0A044, 8'h00, 1'b0);

        // R1: reset in the middle of a write pulse
        while (!ready) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 17'h00055; wdata = 8'h11;
        @(negedge clk);
        req = 1'b0;
        repeat (8) @(negedge clk);
        check(!mem_we_n, "R3 in pulse", mem_we_n, 0);
        rst = 1'b1;
        @(negedge clk);
        check(ready && !rvalid && mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe,
              "R1 reset mid-access", {ready, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe},
              6'b110110);
        @(negedge clk);
        rst = 1'b0;
        do_op(1'b0, 17'h1FFFF, 8'h00, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule